// File: doc/BRIEF.md
# Accelerator Cache Control Decoder

This block watches the upper address bits of a 32-bit processor bus on an accelerator card. It decodes a private register window. Writes to that window carry no data: the address of the access is the whole command. Depending on the command nibble, the access turns the card's external cache on or off, or flushes it. Two further addresses, which software uses inside its cache-on sequence, are only recorded in two sticky status bits. These accesses leave the cache state as it is, and they complete like any other access.

For every qualified access, the block also produces a cache-inhibit qualifier for I/O space. An adapter sense input picks the size of that range. When the adapter grounds the sense input, the whole I/O space is non-cacheable. When the input is left high (the inactive, pulled-up level), only the floppy controller page is non-cacheable. An external active-low flush request can also pulse the flush output. It is idle at its high level, so an unconnected input never causes a flush.

An access is a run of clocks with the strobe high. The access state machine has two states. IDLE moves to HELD on the first strobe cycle (transition "take"), and a command fires only on that transition. HELD stays in HELD while the strobe is high (transition "hold"). HELD returns to IDLE when the strobe drops (transition "release").

Top module: `accel_cache_ctrl`

## Requirements
- R1: `win_sel` is high exactly while `bus_strb` is high and address bits 31..24 equal 0x52; it is combinational on the current inputs.
- R2: An access whose bits 31..16 are 0x5205 sets `cache_on` to 1 at the clock edge that samples the first strobe cycle.
- R3: An access whose bits 31..16 are 0x5206 clears `cache_on` at the clock edge that samples the first strobe cycle.
- R4: An access whose bits 31..16 are 0x520F raises `flush_pls` for exactly the one cycle after that edge, and leaves `cache_on` unchanged.
- R5: A command acts once per access: holding the strobe for several cycles gives no further flush pulse and no further state change.
- R6: An access with bits 31..16 equal to 0x5207 sets `spare_flags[0]`, and one with 0x5204 sets `spare_flags[1]`. Both bits are sticky until reset, and neither access changes `cache_on`.
- R7: Bits 19..16 select the command only when bits 31..20 are 0x520. Bits 15..12 are ignored. All other nibbles (0..3, 8..E) and addresses such as 0x521x_xxxx change nothing.
- R8: With `io_wide_n` low, `no_cache` is high for every strobed access with bits 31..28 equal to 0x5.
- R9: With `io_wide_n` high, `no_cache` is high only for strobed accesses with bits 31..12 equal to 0x50016.
- R10: With `bus_strb` low, `win_sel` and `no_cache` are both low.
- R11: A high-to-low change of `ext_flush_n` gives a single one-cycle `flush_pls` pulse in the cycle after the edge that samples it low. Holding the input low or high gives no pulse.
- R12: After reset, `cache_on`, `flush_pls` and `spare_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hi | input | 20 | Address bits 31..12 |
| bus_strb | input | 1 | High while a qualified access is in progress |
| ext_flush_n | input | 1 | External flush request, active low, idle high |
| io_wide_n | input | 1 | Adapter sense: low selects the whole I/O space as non-cacheable |
| win_sel | output | 1 | Register window select |
| cache_on | output | 1 | External cache enable level |
| flush_pls | output | 1 | One-cycle cache flush pulse |
| no_cache | output | 1 | Cache-inhibit qualifier for the current access |
| spare_flags | output | 2 | Sticky flags for the two spare command addresses |

## Verification
A state machine stuck in HELD would swallow the next command, so `cache_on` would fail to follow the following enable or disable access within one cycle. A state machine that never leaves IDLE would fire again on a held strobe, and this shows up as a second `flush_pls` cycle. A wrong command decode shows at once at the ports in three ways: a spare address moves `cache_on`, a flag bit sets from the wrong address, or `flush_pls` appears for a non-flush nibble. The sense-selected range is combinational and is checked in the same cycle against both settings of `io_wide_n`.

// File: rtl/accel_cache_pkg.sv
package accel_cache_pkg;

    localparam int          ADDR_LSB    = 12;
    localparam int          ADDR_W      = 32 - ADDR_LSB;
    localparam logic [7:0]  WIN_TOP     = 8'h52;
    localparam logic [3:0]  WIN_SUB     = 4'h0;
    localparam logic [3:0]  IO_TOP      = 4'h5;
    localparam logic [19:0] FLOPPY_PAGE = 20'h50016;
    localparam int          SPARE_W     = 2;

    localparam logic [3:0] NIB_SPARE_B = 4'h4;
    localparam logic [3:0] NIB_ON      = 4'h5;
    localparam logic [3:0] NIB_OFF     = 4'h6;
    localparam logic [3:0] NIB_SPARE_A = 4'h7;
    localparam logic [3:0] NIB_FLUSH   = 4'hF;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ON,
        CMD_OFF,
        CMD_FLUSH,
        CMD_SPARE_A,
        CMD_SPARE_B
    } cache_cmd_e;

    typedef enum logic {
        ACC_IDLE,
        ACC_HELD
    } acc_state_e;

endpackage

// File: rtl/accel_addr_decode.sv
module accel_addr_decode
    import accel_cache_pkg::*;
(
    input  logic [31:ADDR_LSB] addr_hi,
    input  logic               bus_strb,
    input  logic               io_wide_n,
    output logic               win_sel,
    output logic               no_cache,
    output cache_cmd_e         cmd
);
    logic in_win;
    logic in_io;
    logic in_floppy;

    always_comb begin
        in_win    = (addr_hi[31:24] == WIN_TOP);
        in_io     = (addr_hi[31:28] == IO_TOP);
        in_floppy = (addr_hi[31:12] == FLOPPY_PAGE);
        win_sel   = bus_strb && in_win;
        no_cache  = bus_strb && (io_wide_n ? in_floppy : in_io);
    end

    always_comb begin
        cmd = CMD_NONE;
        if (in_win && (addr_hi[23:20] == WIN_SUB)) begin
            case (addr_hi[19:16])
                NIB_ON:      cmd = CMD_ON;
                NIB_OFF:     cmd = CMD_OFF;
                NIB_FLUSH:   cmd = CMD_FLUSH;
                NIB_SPARE_A: cmd = CMD_SPARE_A;
                NIB_SPARE_B: cmd = CMD_SPARE_B;
                default:     cmd = CMD_NONE;
            endcase
        end
    end

    logic unused_lo;
    assign unused_lo = ^addr_hi[15:12];

endmodule

// File: rtl/accel_access_fsm.sv
module accel_access_fsm
    import accel_cache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_strb,
    output logic fire
);
    acc_state_e state_q;
    acc_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (bus_strb)  state_d = ACC_HELD;   // take
            ACC_HELD: if (!bus_strb) state_d = ACC_IDLE;   // release, else hold
        endcase
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            ACC_IDLE: fire = bus_strb;
            ACC_HELD: fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/accel_cache_regs.sv
module accel_cache_regs
    import accel_cache_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  cache_cmd_e         cmd,
    input  logic               ext_flush_n,
    output logic               cache_on,
    output logic               flush_pls,
    output logic [SPARE_W-1:0] spare_flags
);
    logic ext_prev_n;
    logic ext_fall;

    assign ext_fall = ext_prev_n && !ext_flush_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cache_on    <= 1'b0;
            flush_pls   <= 1'b0;
            spare_flags <= '0;
            ext_prev_n  <= 1'b1;
        end else begin
            ext_prev_n <= ext_flush_n;
            flush_pls  <= ext_fall || (fire && cmd == CMD_FLUSH);
            if (fire) begin
                case (cmd)
                    CMD_ON:      cache_on       <= 1'b1;
                    CMD_OFF:     cache_on       <= 1'b0;
                    CMD_SPARE_A: spare_flags[0] <= 1'b1;
                    CMD_SPARE_B: spare_flags[1] <= 1'b1;
                    default:     ;
                endcase
            end
        end
    end

endmodule

// File: rtl/accel_cache_ctrl.sv
module accel_cache_ctrl
    import accel_cache_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:ADDR_LSB] addr_hi,
    input  logic               bus_strb,
    input  logic               ext_flush_n,
    input  logic               io_wide_n,
    output logic               win_sel,
    output logic               cache_on,
    output logic               flush_pls,
    output logic               no_cache,
    output logic [SPARE_W-1:0] spare_flags
);
    cache_cmd_e cmd;
    logic       fire;

    accel_addr_decode u_dec (
        .addr_hi   (addr_hi),
        .bus_strb  (bus_strb),
        .io_wide_n (io_wide_n),
        .win_sel   (win_sel),
        .no_cache  (no_cache),
        .cmd       (cmd)
    );

    accel_access_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_strb (bus_strb),
        .fire     (fire)
    );

    accel_cache_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .cmd         (cmd),
        .ext_flush_n (ext_flush_n),
        .cache_on    (cache_on),
        .flush_pls   (flush_pls),
        .spare_flags (spare_flags)
    );

endmodule

// File: rtl/accel_cache_ctrl_chk.sv
module accel_cache_ctrl_chk
    import accel_cache_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [31:ADDR_LSB] addr_hi,
    input logic               bus_strb,
    input logic               ext_flush_n,
    input logic               win_sel,
    input logic               cache_on,
    input logic               flush_pls,
    input logic               no_cache,
    input logic [SPARE_W-1:0] spare_flags
);
    // R1
    win_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hi[31:24] != WIN_TOP) |-> !win_sel);

    // R2
    enable_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_strb) && addr_hi[31:16] == 16'h5205) |=> cache_on);

    // R3
    disable_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_strb) && addr_hi[31:16] == 16'h5206) |=> !cache_on);

    // R6
    spare_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_strb) && (addr_hi[31:16] == 16'h5207 || addr_hi[31:16] == 16'h5204))
        |=> (cache_on == $past(cache_on)));

    // R6
    spare_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spare_flags[0] |=> spare_flags[0]);

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_pls && bus_strb && ext_flush_n) |=> !flush_pls);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strb |-> (!win_sel && !no_cache));

    // R11
    no_spurious_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ext_flush_n) && !$past(bus_strb)) |-> !flush_pls);

endmodule

bind accel_cache_ctrl accel_cache_ctrl_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_hi     (addr_hi),
    .bus_strb    (bus_strb),
    .ext_flush_n (ext_flush_n),
    .win_sel     (win_sel),
    .cache_on    (cache_on),
    .flush_pls   (flush_pls),
    .no_cache    (no_cache),
    .spare_flags (spare_flags)
);

// File: tb/test_accel_cache_ctrl.sv
module test_accel_cache_ctrl;

    localparam int CLK_P = 10;

    typedef struct {
        logic       win;
        logic       en;
        logic       fl;
        logic       nc;
        logic [1:0] sp;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:12] addr_hi = '0;
    logic        bus_strb = 1'b0;
    logic        ext_flush_n = 1'b1;
    logic        io_wide_n = 1'b1;
    logic        win_sel, cache_on, flush_pls, no_cache;
    logic [1:0]  spare_flags;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    logic       m_en = 1'b0;
    logic [1:0] m_sp = 2'b00;
    logic       m_busy = 1'b0;
    logic       m_prev = 1'b1;

    always #(CLK_P/2) clk = ~clk;

    accel_cache_ctrl i_accel_cache_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_hi     (addr_hi),
        .bus_strb    (bus_strb),
        .ext_flush_n (ext_flush_n),
        .io_wide_n   (io_wide_n),
        .win_sel     (win_sel),
        .cache_on    (cache_on),
        .flush_pls   (flush_pls),
        .no_cache    (no_cache),
        .spare_flags (spare_flags)
    );

    task automatic cmp(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected post-edge view
    task automatic step(input logic [31:0] a, input logic s, input logic x_n, input string req);
        exp_t e;
        logic fire;
        logic [15:0] top;
        @(negedge clk);
        addr_hi     = a[31:12];
        bus_strb    = s;
        ext_flush_n = x_n;
        top  = a[31:16];
        fire = s && !m_busy;
        e.fl = (m_prev && !x_n);
        if (fire) begin
            if (top == 16'h5205) m_en = 1'b1;
            if (top == 16'h5206) m_en = 1'b0;
            if (top == 16'h520F) e.fl = 1'b1;
            if (top == 16'h5207) m_sp[0] = 1'b1;
            if (top == 16'h5204) m_sp[1] = 1'b1;
        end
        m_busy = s;
        m_prev = x_n;
        e.en  = m_en;
        e.sp  = m_sp;
        e.win = s && (a[31:24] == 8'h52);
        e.nc  = s && (io_wide_n ? (a[31:12] == 20'h50016) : (a[31:28] == 4'h5));
        e.req = req;
        q.push_back(e);
        @(posedge clk);
    endtask

    task automatic access(input logic [31:0] a, input int len, input string req);
        for (int i = 0; i < len; i++) step(a, 1'b1, 1'b1, req);
        step(a, 1'b0, 1'b1, req);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.req, "win_sel",     {1'b0, win_sel},   {1'b0, e.win});
                cmp(e.req, "cache_on",    {1'b0, cache_on},  {1'b0, e.en});
                cmp(e.req, "flush_pls",   {1'b0, flush_pls}, {1'b0, e.fl});
                cmp(e.req, "no_cache",    {1'b0, no_cache},  {1'b0, e.nc});
                cmp(e.req, "spare_flags", spare_flags,       e.sp);
            end
        end
    end

    initial begin
        #(CLK_P * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        // R12 reset state
        cmp("R12", "cache_on",    {1'b0, cache_on},  2'b0);
        cmp("R12", "flush_pls",   {1'b0, flush_pls}, 2'b0);
        cmp("R12", "spare_flags", spare_flags,       2'b0);
        @(negedge clk);
        rst_n = 1'b1;

        access(32'h5205_0000, 1, "R2");
        access(32'h5206_1234, 1, "R3");
        access(32'h5205_0000, 1, "R2");
        access(32'h520F_0000, 1, "R4");
        access(32'h520F_0000, 4, "R5");
        access(32'h5206_0000, 3, "R5");
        access(32'h5207_0000, 1, "R6");
        access(32'h5205_0000, 1, "R6");
        access(32'h5207_0000, 2, "R6");
        access(32'h5204_0000, 1, "R6");
        access(32'h5203_0000, 1, "R7");
        access(32'h5208_0000, 1, "R7");
        access(32'h521F_0000, 1, "R7");
        access(32'h5216_0000, 1, "R7");
        access(32'h52AB_CDEF, 1, "R1");
        access(32'h5300_0000, 1, "R1");

        io_wide_n = 1'b0;
        access(32'h5000_4000, 1, "R8");
        access(32'h5F12_3000, 1, "R8");
        access(32'h4FFF_F000, 1, "R8");
        access(32'h5001_6000, 1, "R8");
        io_wide_n = 1'b1;
        access(32'h5001_6ABC, 1, "R9");
        access(32'h5001_7000, 1, "R9");
        access(32'h5000_4000, 1, "R9");

        step(32'h5001_6000, 1'b0, 1'b1, "R10");
        step(32'h5200_0000, 1'b0, 1'b1, "R10");

        step(32'h0, 1'b0, 1'b1, "R11");
        step(32'h0, 1'b0, 1'b0, "R11");
        step(32'h0, 1'b0, 1'b0, "R11");
        step(32'h0, 1'b0, 1'b0, "R11");
        step(32'h0, 1'b0, 1'b1, "R11");
        step(32'h0, 1'b0, 1'b1, "R11");
        step(32'h0, 1'b0, 1'b0, "R11");
        step(32'h0, 1'b0, 1'b1, "R11");

        @(negedge clk);
        rst_n = 1'b0;
        m_en = 1'b0; m_sp = 2'b00; m_busy = 1'b0; m_prev = 1'b1;
        #(CLK_P/4);
        // R12 asynchronous reset clears state
        cmp("R12", "cache_on",    {1'b0, cache_on}, 2'b0);
        cmp("R12", "spare_flags", spare_flags,      2'b0);
        @(negedge clk);
        rst_n = 1'b1;
        access(32'h5205_0000, 1, "R2");

        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule